// File: doc/BRIEF.md
# USB Line State Monitor

This block watches the three digitized receiver bits of a USB port: the two single-ended comparators and the differential receiver. Every cycle it reports which of four states the pair is in. J and K are told apart by the differential bit, and their polarity follows the speed the port runs at. On top of that state it raises one-cycle pulses for the timed bus events a link layer acts on: a packet starting, a packet ending, a bus reset, and a device leaving or arriving.

Time is measured from two strobes supplied by the surrounding logic. A one-microsecond tick times reset, connect and disconnect. A bit-time strobe from clock recovery times the single-ended-zero that closes a packet. All thresholds are parameters. Each event fires once per qualifying episode and is armed again only after the line has left that condition.

Top module: `usb_line_monitor`

## Requirements
- R1: `line_state` is registered one clock after the inputs and encodes 2'b00 = SE0 (both single-ended bits low), 2'b11 = SE1 (both high), 2'b01 = J, 2'b10 = K.
- R2: With `low_speed` = 0, J is reported for `diff_rx` = 1 and K for `diff_rx` = 0. With `low_speed` = 1 the mapping is inverted.
- R3: `sop` is high for exactly the one cycle in which `line_state` is K and was J in the cycle before.
- R4: `eop` is high for the one cycle in which `line_state` first shows J after an SE0, provided at least EOP_BITS `bit_strobe` pulses were sampled while `line_state` was SE0.
- R5: An SE0 that is followed by K or by SE1 produces no `eop`. SE1 never counts as SE0.
- R6: `bus_reset` pulses one cycle after the edge that samples the RESET_US-th `us_tick` of an unbroken SE0 on `line_state`.
- R7: `disconnect` pulses one cycle after the edge that samples the DISC_US-th `us_tick` of an unbroken SE0 on `line_state`.
- R8: `connect` pulses one cycle after the edge that samples the CONN_US-th `us_tick` during which `line_state` is not SE0 without a break.
- R9: `bus_reset`, `disconnect` and `connect` fire at most once per episode, however long the condition lasts. They fire again only after the line leaves the condition and enters it anew.
- R10: While `rst_n` is low, `line_state` is SE0 and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_speed | input | 1 | 1 selects low-speed J/K polarity |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| bit_strobe | input | 1 | One-cycle strobe once per bit time |
| dp_se | input | 1 | D+ single-ended comparator is high |
| dm_se | input | 1 | D- single-ended comparator is high |
| diff_rx | input | 1 | Differential receiver output |
| line_state | output | 2 | Classified line state |
| sop | output | 1 | Start-of-packet pulse |
| eop | output | 1 | End-of-packet pulse |
| bus_reset | output | 1 | Reset-detected pulse |
| disconnect | output | 1 | Disconnect pulse |
| connect | output | 1 | Connect pulse |

## Verification
The bench builds the block with RESET_US = 3, DISC_US = 5, CONN_US = 4 and EOP_BITS = 2 instead of the defaults. Because the reset and disconnect thresholds differ, the two pulses land on different ticks, so a swapped or shared comparison shows up. A two-bit end-of-packet minimum separates an SE0 that is one bit long from one that is long enough. The microsecond tick arrives every 8 clocks, so every timed event can be reached within a few dozen cycles.

// File: rtl/usb_line_monitor.sv
module usb_line_monitor #(
  parameter int RESET_US = 3,
  parameter int DISC_US  = 3,
  parameter int CONN_US  = 3,
  parameter int EOP_BITS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_speed,
  input  logic       us_tick,
  input  logic       bit_strobe,
  input  logic       dp_se,
  input  logic       dm_se,
  input  logic       diff_rx,
  output logic [1:0] line_state,
  output logic       sop,
  output logic       eop,
  output logic       bus_reset,
  output logic       disconnect,
  output logic       connect
);

  localparam int SE0_MAX = (RESET_US > DISC_US) ? RESET_US : DISC_US;
  localparam int UW = $clog2(SE0_MAX + 1);
  localparam int CW = $clog2(CONN_US + 1);
  localparam int BW = $clog2(EOP_BITS + 1);

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam logic [1:0] LS_SE1 = 2'b11;

  logic [1:0]    cls, st, prev;
  logic [BW-1:0] se0_bits;
  logic [UW-1:0] se0_us;
  logic [CW-1:0] hi_us;
  logic          in_se0;

  always_comb begin
    case ({dp_se, dm_se})
      2'b00:   cls = LS_SE0;
      2'b11:   cls = LS_SE1;
      default: cls = (diff_rx ^ low_speed) ? LS_J : LS_K;
    endcase
  end

  assign in_se0 = (st == LS_SE0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= LS_SE0;
      prev       <= LS_SE0;
      se0_bits   <= '0;
      se0_us     <= '0;
      hi_us      <= '0;
      bus_reset  <= 1'b0;
      disconnect <= 1'b0;
      connect    <= 1'b0;
    end else begin
      st   <= cls;
      prev <= st;

      if (!in_se0)
        se0_bits <= '0;
      else if (bit_strobe && se0_bits != BW'(EOP_BITS))
        se0_bits <= se0_bits + 1'b1;

      if (!in_se0)
        se0_us <= '0;
      else if (us_tick && se0_us != UW'(SE0_MAX))
        se0_us <= se0_us + 1'b1;

      if (in_se0)
        hi_us <= '0;
      else if (us_tick && hi_us != CW'(CONN_US))
        hi_us <= hi_us + 1'b1;

      bus_reset  <= in_se0 && us_tick && se0_us == UW'(RESET_US - 1);
      disconnect <= in_se0 && us_tick && se0_us == UW'(DISC_US - 1);
      connect    <= !in_se0 && us_tick && hi_us == CW'(CONN_US - 1);
    end
  end

  assign line_state = st;
  assign sop = (prev == LS_J) && (st == LS_K);
  assign eop = (prev == LS_SE0) && (st == LS_J) && (se0_bits == BW'(EOP_BITS));

  a_r3_sop_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sop |-> $past(line_state) == LS_J);

  a_r4_eop_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> $past(line_state) == LS_SE0 && line_state == LS_J);

  a_r5_no_eop_from_se1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_state) == LS_SE1 |-> !eop);

  a_r6_reset_in_se0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |-> $past(line_state) == LS_SE0);

  a_r7_disc_in_se0: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> $past(line_state) == LS_SE0);

  a_r8_connect_not_se0: assert property (@(posedge clk) disable iff (!rst_n)
    connect |-> $past(line_state) != LS_SE0);

  a_r9_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  a_r9_disc_single: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |=> !disconnect);

  a_r9_connect_single: assert property (@(posedge clk) disable iff (!rst_n)
    connect |=> !connect);

endmodule

// File: tb/usb_line_monitor_tb_top.sv
module usb_line_monitor_tb_top;
  localparam int RST_US = 3, DSC_US = 5, CON_US = 4, EOP_B = 2, TICK_DIV = 8;

  logic clk = 1'b0, rst_n = 1'b0, low_speed = 1'b0, us_tick = 1'b0, bit_strobe = 1'b0;
  logic dp_se = 1'b0, dm_se = 1'b0, diff_rx = 1'b0;
  logic [1:0] line_state;
  logic sop, eop, bus_reset, disconnect, connect;

  always #4 clk = ~clk;

  usb_line_monitor #(.RESET_US(RST_US), .DISC_US(DSC_US), .CONN_US(CON_US), .EOP_BITS(EOP_B)) dut_i (
    .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .us_tick(us_tick), .bit_strobe(bit_strobe),
    .dp_se(dp_se), .dm_se(dm_se), .diff_rx(diff_rx), .line_state(line_state), .sop(sop),
    .eop(eop), .bus_reset(bus_reset), .disconnect(disconnect), .connect(connect));

  int n_cmp = 0, n_bad = 0, tick_ctr = 0, strobe_mode = 0;
  int c_sop = 0, c_eop = 0, c_rst = 0, c_dsc = 0, c_con = 0;
  bit done = 1'b0;

  // expected-value model, timed from the requirements
  logic [1:0] m_st = 2'b00, m_prev = 2'b00;
  int m_bits = 0, m_se0 = 0, m_hi = 0;
  logic m_rst = 1'b0, m_dsc = 1'b0, m_con = 1'b0;

  function automatic logic [1:0] f_class(logic dp, logic dm, logic df, logic ls);
    if (!dp && !dm) return 2'b00;
    if (dp && dm) return 2'b11;
    return (df != ls) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic f_sop(logic [1:0] p, logic [1:0] s);
    return p == 2'b01 && s == 2'b10;
  endfunction

  function automatic logic f_eop(logic [1:0] p, logic [1:0] s, int bits);
    return p == 2'b00 && s == 2'b01 && bits >= EOP_B;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 2'b00; m_prev <= 2'b00; m_bits <= 0; m_se0 <= 0; m_hi <= 0;
      m_rst <= 1'b0; m_dsc <= 1'b0; m_con <= 1'b0;
    end else begin
      m_rst <= (m_st == 2'b00) && us_tick && (m_se0 + 1 == RST_US);
      m_dsc <= (m_st == 2'b00) && us_tick && (m_se0 + 1 == DSC_US);
      m_con <= (m_st != 2'b00) && us_tick && (m_hi + 1 == CON_US);
      m_bits <= (m_st != 2'b00) ? 0 : m_bits + ((bit_strobe && m_bits < EOP_B) ? 1 : 0);
      m_se0 <= (m_st != 2'b00) ? 0 : m_se0 + ((us_tick && m_se0 < 64) ? 1 : 0);
      m_hi  <= (m_st == 2'b00) ? 0 : m_hi + ((us_tick && m_hi < 64) ? 1 : 0);
      m_st <= f_class(dp_se, dm_se, diff_rx, low_speed);
      m_prev <= m_st;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 line_state", line_state, m_st);
    chk("R3 sop", sop, f_sop(m_prev, m_st));
    chk("R4 eop", eop, f_eop(m_prev, m_st, m_bits));
    chk("R6 bus_reset", bus_reset, m_rst);
    chk("R7 disconnect", disconnect, m_dsc);
    chk("R8 connect", connect, m_con);
    c_sop += sop; c_eop += eop; c_rst += bus_reset; c_dsc += disconnect; c_con += connect;
  endtask

  // called at a falling edge: drive, let one rising edge pass, compare at the next falling edge
  task automatic step(logic [1:0] want);
    logic d;
    case (want)
      2'b00: begin dp_se = 1'b0; dm_se = 1'b0; diff_rx = 1'($urandom); end
      2'b11: begin dp_se = 1'b1; dm_se = 1'b1; diff_rx = 1'($urandom); end
      default: begin
        d = (want == 2'b01) ? ~low_speed : low_speed;
        diff_rx = d; dp_se = d; dm_se = ~d;
      end
    endcase
    us_tick = (tick_ctr % TICK_DIV) == TICK_DIV - 1;
    tick_ctr++;
    bit_strobe = (strobe_mode == 1) ? 1'b1 : (($urandom % 3) == 0);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic hold(logic [1:0] want, int n);
    for (int i = 0; i < n; i++) step(want);
  endtask

  task automatic clear_counts();
    c_sop = 0; c_eop = 0; c_rst = 0; c_dsc = 0; c_con = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    hold(2'b01, 3);
    chk("R10 reset line_state", line_state, 0);
    chk("R10 reset pulses", {sop, eop, bus_reset, disconnect, connect}, 0);
    rst_n = 1'b1;
    hold(2'b01, 2);
    chk("R1 idle J full speed", line_state, 1);

    // R2: low-speed polarity
    low_speed = 1'b1;
    dp_se = 1'b0; dm_se = 1'b1; diff_rx = 1'b0;
    @(posedge clk); @(negedge clk); compare_all();
    chk("R2 low speed J on diff 0", line_state, 2'b01);
    dp_se = 1'b1; dm_se = 1'b0; diff_rx = 1'b1;
    @(posedge clk); @(negedge clk); compare_all();
    chk("R2 low speed K on diff 1", line_state, 2'b10);
    low_speed = 1'b0;
    hold(2'b01, 4);

    // R3 and R4: packet framing with a long enough SE0
    clear_counts();
    strobe_mode = 1;
    hold(2'b10, 3);
    hold(2'b00, 3);
    hold(2'b01, 2);
    chk("R3 one sop", c_sop, 1);
    chk("R4 one eop", c_eop, 1);

    // R4: SE0 one bit long is too short
    clear_counts();
    hold(2'b00, 1);
    hold(2'b01, 2);
    chk("R4 short SE0 no eop", c_eop, 0);

    // R5: SE0 ending in K or SE1
    clear_counts();
    hold(2'b00, 4); hold(2'b10, 2); hold(2'b01, 2);
    hold(2'b00, 4); hold(2'b11, 1); hold(2'b01, 2);
    chk("R5 no eop without J", c_eop, 0);
    strobe_mode = 0;

    // R6, R7, R9: long SE0 gives one reset and one disconnect
    clear_counts();
    hold(2'b00, 100);
    chk("R6 single reset", c_rst, 1);
    chk("R7 single disconnect", c_dsc, 1);
    // R8, R9: long idle gives one connect
    hold(2'b01, 80);
    chk("R8 single connect", c_con, 1);
    // R9: re-armed after leaving SE0
    hold(2'b00, 100);
    chk("R9 reset re-armed", c_rst, 2);
    chk("R9 disconnect re-armed", c_dsc, 2);
    hold(2'b01, 80);
    chk("R9 connect re-armed", c_con, 2);

    // random segments
    for (int s = 0; s < 700; s++) begin
      int r;
      logic [1:0] w;
      if (($urandom % 16) == 0) low_speed = ~low_speed;
      r = $urandom % 10;
      w = (r < 3) ? 2'b00 : (r < 6) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      hold(w, 1 + ($urandom % ((w == 2'b00) ? 50 : 12)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule